// File: doc/BRIEF.md
# Modular halving and quartering unit

This block divides a signed residue by two or by four modulo an odd modulus in one pass, with no iteration. Before it shifts, it makes the operand exactly divisible by adding a small multiple of the modulus. For halving, that multiple is 0 or +M. For quartering, it is one of 0, -M, +M or +2M. The multiple is chosen only from the two lowest bits of the operand and from bit 1 of the modulus. The adjusted value is then shifted right arithmetically, so negative operands keep their sign.

The intended user is a binary-GCD style modular divider. That loop only needs its auxiliary variable to stay congruent and bounded, so the result is not reduced into [0, M). The operand is two's complement and two bits wider than the modulus. The internal sum carries one more bit, so even an operand at either extreme plus 2M or minus M cannot wrap. A parameter selects between a registered output with one cycle of latency (the default) and a purely combinational output.

Top module: `mod_halfquart`

## Requirements
- R1: In halve mode (`quarter_i` = 0) with an even operand, the result equals T/2.
- R2: In halve mode with an odd operand, the result equals (T+M)/2. Bit 1 of M plays no part in this choice.
- R3: In quarter mode (`quarter_i` = 1) with M mod 4 = 1, the added multiple is 0, -M, +2M or +M when T mod 4 is 0, 1, 2 or 3. T mod 4 is taken from bits [1:0] of the two's complement operand.
- R4: In quarter mode with M mod 4 = 3, the added multiple is 0, +M, +2M or -M when T mod 4 is 0, 1, 2 or 3.
- R5: The adjusted sum is always exactly divisible by the divisor. As a result, 2·out ≡ T (mod M) in halve mode and 4·out ≡ T (mod M) in quarter mode.
- R6: The shift is arithmetic. A negative operand gives the correctly signed quotient of a negative sum.
- R7: For any operand in the full signed range of W+2 bits and any odd M below 2^W, the result is exact and does not overflow. This includes T at the maximum with +2M and T at the minimum with -M.
- R8: With OUT_REG = 1, the result appears on `q_o` on the clock edge after the inputs. It is 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| quarter_i | input | 1 | 0 = divide by two, 1 = divide by four |
| t_i | input | W+2 | Signed operand T, two's complement |
| m_i | input | W | Odd modulus M |
| q_o | output | W+2 | Signed result, congruent to T/2 or T/4 mod M |

## Verification
The bench sweeps every pair of T mod 4 and M mod 4 in quarter mode. A selector that swapped the -M and +M entries for one modulus class would leave a sum that is not divisible by four, and that shows up as a wrong quotient and a broken congruence. Negative operands are driven so that a logical shift would expose itself as a huge positive result. The extreme operands, the largest positive with +2M and the most negative with -M, are aimed at a sum too narrow by one bit: such a sum would wrap and flip the sign of the output. A pseudo-random sweep in both modes also checks the congruence independently of the selection table.

// File: rtl/mhq_pkg.sv
package mhq_pkg;

  // Multiple of the modulus that is added before the shift.
  typedef enum logic [1:0] {
    ADD_NONE = 2'd0,
    ADD_NEG1 = 2'd1,
    ADD_POS1 = 2'd2,
    ADD_POS2 = 2'd3
  } mult_e;

  // Chooses the multiple from the mode, bit 1 of the odd modulus and T mod 4.
  function automatic mult_e pick_mult(input logic quarter, input logic mod_b1,
                                      input logic [1:0] t_lo);
    mult_e k;
    if (!quarter) begin
      k = t_lo[0] ? ADD_POS1 : ADD_NONE;
    end else begin
      unique case (t_lo)
        2'd0:    k = ADD_NONE;
        2'd2:    k = ADD_POS2;
        2'd1:    k = mod_b1 ? ADD_POS1 : ADD_NEG1;
        default: k = mod_b1 ? ADD_NEG1 : ADD_POS1;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/mhq_select.sv
module mhq_select
  import mhq_pkg::*;
(
  input  logic       quarter,
  input  logic       mod_b1,
  input  logic [1:0] t_lo,
  output mult_e      mult
);
  always_comb mult = pick_mult(quarter, mod_b1, t_lo);
endmodule

// File: rtl/mhq_addshift.sv
module mhq_addshift
  import mhq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                 quarter,
  input  logic signed [W+1:0]  t_val,
  input  logic        [W-1:0]  m_val,
  input  mult_e                mult,
  output logic signed [W+2:0]  sum,
  output logic signed [W+1:0]  res
);
  localparam int TW = W + 2;
  localparam int SW = W + 3;

  logic signed [SW-1:0] t_ext;
  logic signed [SW-1:0] m_ext;
  logic signed [SW-1:0] term;

  always_comb begin
    t_ext = {t_val[TW-1], t_val};
    m_ext = {3'b000, m_val};
    unique case (mult)
      ADD_NONE: term = '0;
      ADD_NEG1: term = -m_ext;
      ADD_POS1: term = m_ext;
      default:  term = m_ext <<< 1;
    endcase
    sum = t_ext + term;
    // Arithmetic shift: the sign bit of the widened sum is replicated.
    if (quarter) res = {sum[SW-1], sum[SW-1:2]};
    else         res = sum[SW-1:1];
  end
endmodule

// File: rtl/mhq_outstage.sv
module mhq_outstage #(
  parameter int TW      = 34,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [TW-1:0] d,
  output logic signed [TW-1:0] q
);
  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end else begin : g_wire
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/mod_halfquart.sv
module mod_halfquart
  import mhq_pkg::*;
#(
  parameter int W       = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   quarter_i,
  input  logic signed [W+1:0]    t_i,
  input  logic        [W-1:0]    m_i,
  output logic signed [W+1:0]    q_o
);
  localparam int TW = W + 2;
  localparam int SW = W + 3;

  mult_e                mult_sel;
  logic signed [SW-1:0] adj_sum;
  logic signed [TW-1:0] res_comb;

  mhq_select u_sel (
    .quarter (quarter_i),
    .mod_b1  (m_i[1]),
    .t_lo    (t_i[1:0]),
    .mult    (mult_sel)
  );

  mhq_addshift #(.W(W)) u_add (
    .quarter (quarter_i),
    .t_val   (t_i),
    .m_val   (m_i),
    .mult    (mult_sel),
    .sum     (adj_sum),
    .res     (res_comb)
  );

  mhq_outstage #(.TW(TW), .OUT_REG(OUT_REG)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (res_comb),
    .q     (q_o)
  );
endmodule

// File: rtl/mhq_chk.sv
module mhq_chk #(
  parameter int W       = 32,
  parameter bit OUT_REG = 1'b1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 quarter_i,
  input logic signed [W+1:0]  t_i,
  input logic        [W-1:0]  m_i,
  input logic signed [W+2:0]  adj_sum,
  input logic signed [W+1:0]  res_comb,
  input logic signed [W+1:0]  q_o
);
  localparam int SW = W + 3;

  logic signed [SW-1:0] t_x;
  logic signed [SW-1:0] m_x;
  logic signed [SW-1:0] diff;
  assign t_x  = {t_i[W+1], t_i};
  assign m_x  = {3'b000, m_i};
  assign diff = adj_sum - t_x;

  // R1, R2: halving adds nothing or +M
  a_r2_halve_mult: assert property (@(posedge clk) disable iff (!rst_n)
    !quarter_i |-> (diff == '0 || diff == m_x));

  // R1: an even operand in halve mode is left untouched
  a_r1_even_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (!quarter_i && !t_i[0]) |-> diff == '0);

  // R3, R4: quartering adds one of 0, -M, +M, +2M
  a_r3_quarter_mult: assert property (@(posedge clk) disable iff (!rst_n)
    quarter_i |-> (diff == '0 || diff == m_x || diff == -m_x || diff == (m_x <<< 1)));

  // R5: the adjusted sum is exactly divisible
  a_r5_divisible: assert property (@(posedge clk) disable iff (!rst_n)
    quarter_i ? (adj_sum[1:0] == 2'b00) : (adj_sum[0] == 1'b0));

  // R6: the result keeps the sign of the adjusted sum
  a_r6_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    res_comb[W+1] == adj_sum[SW-1]);

  // R7: the shifted result scaled back equals the full-width sum
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    quarter_i ? ($signed({res_comb, 2'b00}) == $signed({adj_sum[SW-1], adj_sum}))
              : ($signed({res_comb, 1'b0}) == adj_sum));

  // R8: registered output follows the combinational result by one edge
  generate
    if (OUT_REG) begin : g_regchk
      a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> q_o == $past(res_comb));
    end
  endgenerate
endmodule

bind mod_halfquart mhq_chk #(.W(W), .OUT_REG(OUT_REG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .quarter_i (quarter_i),
  .t_i       (t_i),
  .m_i       (m_i),
  .adj_sum   (adj_sum),
  .res_comb  (res_comb),
  .q_o       (q_o)
);

// File: tb/sim_mod_halfquart.sv
`timescale 1ns/1ps
module sim_mod_halfquart;
  localparam int W  = 32;
  localparam int TW = W + 2;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 quarter_i = 1'b0;
  logic signed [TW-1:0] t_i = '0;
  logic        [W-1:0]  m_i = '0;
  logic signed [TW-1:0] q_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mod_halfquart #(.W(W), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .quarter_i(quarter_i),
    .t_i(t_i), .m_i(m_i), .q_o(q_o)
  );

  // Expected value: find the multiple of M that makes T divisible.
  function automatic longint expect_val(longint t, longint m, bit q);
    longint dv = q ? 4 : 2;
    longint ks[4] = '{0, 1, -1, 2};
    for (int i = 0; i < 4; i++) begin
      longint s = t + ks[i] * m;
      if (!q && i > 1) break;
      if ((s % dv) == 0) return s / dv;
    end
    return 64'h7fff_ffff_ffff_ffff;
  endfunction

  task automatic apply(input string req, input longint t, input longint m, input bit q);
    longint exp_v, got, cong;
    @(negedge clk);
    t_i = t[TW-1:0];
    m_i = m[W-1:0];
    quarter_i = q;
    @(negedge clk);
    got   = longint'(q_o);
    exp_v = expect_val(t, m, q);
    checks++;
    if (got != exp_v) begin
      fails++;
      $display("FAIL %s: T=%0d M=%0d q=%0b got %0d expected %0d", req, t, m, q, got, exp_v);
    end
    cong = ((q ? 4 : 2) * got - t) % m;
    checks++;
    if (cong != 0) begin
      fails++;
      $display("FAIL R5 (%s): congruence residue got %0d expected 0", req, cong);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    checks++;
    if (q_o !== '0) begin
      fails++;
      $display("FAIL R8: reset output got %0d expected 0", q_o);
    end
  endtask

  task automatic t_halve;
    apply("R1", 40, 13, 1'b0);
    apply("R1", 0, 7, 1'b0);
    apply("R2", 41, 13, 1'b0);
    apply("R2", 41, 15, 1'b0);   // M mod 4 = 3, same rule
  endtask

  task automatic t_quarter_m1;
    for (int r = 0; r < 4; r++) apply("R3", 100 + r, 13, 1'b1);
  endtask

  task automatic t_quarter_m3;
    for (int r = 0; r < 4; r++) apply("R4", 100 + r, 19, 1'b1);
  endtask

  task automatic t_negative;
    apply("R6", -7, 13, 1'b1);    // expect -5
    apply("R6", -8, 13, 1'b0);    // expect -4
    apply("R6", -3, 11, 1'b0);    // expect 4
    for (int r = 0; r < 4; r++) apply("R6", -200 - r, 19, 1'b1);
  endtask

  task automatic t_extremes;
    longint mx = (longint'(1) << (W + 1)) - 1;
    longint mn = -(longint'(1) << (W + 1));
    longint mbig = (longint'(1) << W) - 1;
    apply("R7", mx - 1, mbig, 1'b1);             // +2M at top
    apply("R7", mn + 1, mbig - 2, 1'b1);         // -M at bottom, M mod 4 = 1
    apply("R7", mn + 3, mbig, 1'b1);             // -M at bottom, M mod 4 = 3
    apply("R7", mx, mbig, 1'b0);                 // odd top in halve
    apply("R7", mn, mbig, 1'b1);
  endtask

  task automatic t_sweep;
    logic [63:0] lf = 64'hACE1_2468_1357_BDF9;
    for (int i = 0; i < 200; i++) begin
      longint t, m;
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      t = longint'($signed(lf[TW-1:0]));
      m = longint'({lf[63:33], 1'b1});
      if (m < 3) m = 3;
      apply("R5", t, m, lf[40]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_halve();
    t_quarter_m1();
    t_quarter_m3();
    t_negative();
    t_extremes();
    t_sweep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule